// File: doc/BRIEF.md
# Clocked serial interface controller

This block moves one frame of 2 to 16 bits over a three-wire synchronous serial link: a serial clock, a data output and a data input. Software sets it up through a small register port. One control word holds the configuration. A status word reports the busy flag and the overrun flag. A data location is written to send a frame and read to collect the received frame. Two single-cycle interrupt pulses go to the processor. One fires when a frame is loaded into the shift engine. The other fires when a received frame is complete.

The serial clock comes from the system clock divided by a power of two, or from an external clock pin when the block works as a slave. Clock polarity and data phase are both programmable. In the shifted-phase setting, the busy flag stays set for half a serial clock after the receive-complete pulse. There are two transfer modes. In single mode, a request made while busy is dropped. In continuous mode, a request made while busy is queued, and the next frame starts at the very edge that completes the current one. While the power bit is set, every configuration field is locked. Clearing the power bit brings the shifting state, the receive state and the flags back to idle.

Register port map: address 0 is the control word, address 1 is the status word, and address 2 is the transmit data (on write) and the receive data (on read).

Top module: `csi_ctrl`

## Requirements
- R1: Control word layout: bit 0 power, bit 1 transmit enable, bit 2 receive enable, bit 3 LSB-first, bit 4 continuous mode, bit 5 clock polarity, bit 6 shifted phase, bits 9:7 clock select, bits 13:10 frame length. It reads back as written. The status word has busy at bit 0 and overrun at bit 1. After reset, every register reads 0.
- R2: While power is 1, a control write changes only the power bit. All other fields keep their values.
- R3: One cycle after power reads 0, busy and overrun are 0, the receive data reads 0, and the serial clock rests at its idle level.
- R4: With power 1, transmit enabled and busy 0, a data write loads the frame. Busy and the transmit pulse are high in the next cycle, and the data output shows the first bit.
- R5: In single mode, a data write while busy is dropped. It raises no transmit pulse and starts no later frame.
- R6: With transmit off and receive on, a read of the receive data while idle starts a reception. The same read while busy starts nothing.
- R7: In continuous mode, a request made while busy is queued. The queued frame loads on the completion edge, so busy stays 1 and the transmit pulse coincides with the receive pulse.
- R8: A length value of 0 gives 16 bits, a value of 1 gives 2 bits, and any other value gives that many bits. Bit order follows the LSB-first bit. Received bits above the frame length read 0.
- R9: Clock select k from 0 to 6 gives a half period of 2^k system clocks, so a frame of N bits completes 2·N·2^k cycles after the load. Select 7 takes its edges from the external clock pin, and in that case the serial clock output stays at the idle level.
- R10: With the phase bit 0, busy clears on the same edge that raises the receive pulse. With the phase bit 1, busy clears one half period later.
- R11: Overrun sets when a frame completes while the previous frame is unread. Writing 1 to status bit 1 clears it. A read that lands on the completion edge returns the old data and does not count as an overrun.
- R12: When idle, the serial clock output equals the polarity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumes receive data) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Serial clock output |
| sdo | output | 1 | Serial data output |
| sdi | input | 1 | Serial data input |
| irq_rx | output | 1 | Receive-complete pulse |
| irq_tx | output | 1 | Frame-loaded pulse |

## Verification
Two functions can act on the same edge. A processor read of the receive data can land on the edge where a new frame completes. A queued continuous-mode request can also launch on that edge. The bench times a read exactly onto the 16th half-period edge of an 8-bit frame. It then judges three things: the read returns the previous frame, overrun stays 0, and a later read returns the new frame. For the continuous case, the bench watches for the receive pulse and requires busy and the transmit pulse to be high in that same cycle.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 4;
  localparam int CKS_W  = 3;
  localparam int CTRL_W = LEN_W + CKS_W + 7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Packed order matches control word bits 13..1 (bit 0 is power).
  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [CKS_W-1:0] cks;
    logic             cpha;
    logic             cpol;
    logic             cont;
    logic             lsb;
    logic             rxe;
    logic             txe;
  } csi_cfg_t;
endpackage

// File: rtl/csi_cfg.sv
module csi_cfg
  import csi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic              pwr,
  output csi_cfg_t          cfg
);
  logic     pwr_d;
  csi_cfg_t cfg_d;

  always_comb begin
    pwr_d = pwr;
    cfg_d = cfg;
    if (wr_en) begin
      pwr_d = wdata[0];
      if (!pwr) cfg_d = csi_cfg_t'(wdata[CTRL_W-1:1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr <= 1'b0;
      cfg <= '0;
    end else begin
      pwr <= pwr_d;
      cfg <= cfg_d;
    end
  end

  // Configuration fields cannot move while the interface is powered.
  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr |=> $stable(cfg));
endmodule

// File: rtl/csi_clkgen.sv
module csi_clkgen
  import csi_pkg::*;
#(
  parameter int SEL_W = CKS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic             sck_in,
  output logic             tick
);
  localparam int              CNT_W   = (1 << SEL_W) - 2;
  localparam logic [SEL_W-1:0] SEL_EXT = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [2:0]       sync_q;
  logic             ext, hit;

  always_comb begin
    lim   = ~({CNT_W{1'b1}} << sel);
    ext   = (sel == SEL_EXT);
    hit   = (cnt_q == lim);
    tick  = run & (ext ? (sync_q[1] ^ sync_q[2]) : hit);
    cnt_d = (restart | ~run | hit) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= {sync_q[1:0], sck_in};
    end
  end

  // Internal divider: two ticks are never closer than the divider allows.
  assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ext && sel != '0 && !restart) |=> !tick);
endmodule

// File: rtl/csi_shift.sv
module csi_shift
  import csi_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [DW-1:0] load,
  input  logic          lsb,
  input  logic          cpha,
  input  logic          txe,
  input  logic [LW-1:0] len,
  input  logic          tick,
  input  logic          sin,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          sout,
  output logic          tgl
);
  localparam int CW = LW + 2;

  logic [CW-1:0] hcnt_q, hcnt_d, last, hm1;
  logic [LW:0]   nbits, k_out, k_in;
  logic [LW-1:0] pos_out, pos_in;
  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d, rx_nx;
  logic          busy_d, tgl_d, sample, fin, step;

  always_comb begin
    nbits = (len == '0) ? (LW+1)'(DW) : (len == LW'(1)) ? (LW+1)'(2) : {1'b0, len};
    last  = {nbits, 1'b0};
    hm1   = hcnt_q - CW'(1);
    k_out = cpha ? ((hcnt_q == '0) ? '0 : hm1[CW-1:1]) : hcnt_q[CW-1:1];
    if (k_out >= nbits) k_out = nbits - (LW+1)'(1);
    k_in    = hcnt_q[CW-1:1];
    pos_out = lsb ? k_out[LW-1:0] : LW'(nbits - (LW+1)'(1) - k_out);
    pos_in  = lsb ? k_in[LW-1:0]  : LW'(nbits - (LW+1)'(1) - k_in);
    step    = tick & busy;
    sample  = step & (hcnt_q < last) & (hcnt_q[0] == cpha);
    done    = step & (hcnt_q == last - CW'(1));
    fin     = cpha ? (step & (hcnt_q == last)) : done;
    rx_nx   = rx_q;
    if (sample) rx_nx[pos_in] = sin;
    word    = rx_nx;
    sout    = txe & busy & tx_q[pos_out];
  end

  always_comb begin
    busy_d = busy;
    hcnt_d = hcnt_q;
    tgl_d  = tgl;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (clr) begin
      busy_d = 1'b0;
      hcnt_d = '0;
      tgl_d  = 1'b0;
      rx_d   = '0;
    end else if (start) begin
      busy_d = 1'b1;
      hcnt_d = '0;
      tgl_d  = 1'b0;
      tx_d   = load;
      rx_d   = '0;
    end else if (step) begin
      hcnt_d = hcnt_q + CW'(1);
      if (hcnt_q < last) tgl_d = ~tgl;
      rx_d = rx_nx;
      if (fin) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      hcnt_q <= '0;
      tgl    <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy   <= busy_d;
      hcnt_q <= hcnt_d;
      tgl    <= tgl_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  // Shifted phase keeps busy for one more half period after completion.
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cpha && !start && !clr) |=> busy);
  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cpha && !start && !clr) |=> !busy);
  // The clock line is back at rest whenever the engine is idle.
  assert_idle_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tgl);
endmodule

// File: rtl/csi_ctrl.sv
module csi_ctrl
  import csi_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sdo,
  input  logic          sdi,
  output logic          irq_rx,
  output logic          irq_tx
);
  localparam logic [CKS_W-1:0] SEL_EXT = '1;

  logic [1:0]    rsync_q;
  logic          srst_n;
  logic          pwr, busy, done, tick, tgl;
  csi_cfg_t      cfg;
  logic          ctrl_wr, stat_wr, tx_wr, rx_rd, rx_only, req, launch, start, cap;
  logic [DW-1:0] word, start_data, hold_q, hold_d, rx_q, rx_d;
  logic          pend_q, pend_d, full_q, full_d, ovr_q, ovr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  always_comb begin
    ctrl_wr    = reg_wr & (reg_addr == ADDR_CTRL);
    stat_wr    = reg_wr & (reg_addr == ADDR_STAT);
    tx_wr      = reg_wr & (reg_addr == ADDR_DATA);
    rx_rd      = reg_rd & (reg_addr == ADDR_DATA);
    rx_only    = ~cfg.txe & cfg.rxe;
    req        = pwr & ((tx_wr & cfg.txe) | (rx_rd & rx_only));
    launch     = pend_q & (done | ~busy);
    start      = launch | (req & ~busy);
    start_data = launch ? hold_q : reg_wdata;
    cap        = done & cfg.rxe & pwr;

    pend_d = pend_q;
    hold_d = hold_q;
    if (launch) pend_d = 1'b0;
    if (req & cfg.cont & (busy | launch)) begin
      pend_d = 1'b1;
      hold_d = reg_wdata;
    end
    if (!pwr) pend_d = 1'b0;

    rx_d   = !pwr ? '0   : cap ? word : rx_q;
    full_d = !pwr ? 1'b0 : cap ? 1'b1 : rx_rd ? 1'b0 : full_q;
    if (!pwr)                           ovr_d = 1'b0;
    else if (cap & full_q & ~rx_rd)     ovr_d = 1'b1;
    else if (stat_wr & reg_wdata[1])    ovr_d = 1'b0;
    else                                ovr_d = ovr_q;

    case (reg_addr)
      ADDR_CTRL: reg_rdata = DW'({cfg, pwr});
      ADDR_STAT: reg_rdata = DW'({ovr_q, busy});
      ADDR_DATA: reg_rdata = rx_q;
      default:   reg_rdata = '0;
    endcase
    sck_out = (cfg.cks == SEL_EXT) ? cfg.cpol : (cfg.cpol ^ tgl);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      rx_q   <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
    end else begin
      pend_q <= pend_d;
      hold_q <= hold_d;
      rx_q   <= rx_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      irq_rx <= cap;
      irq_tx <= start & cfg.txe & pwr;
    end
  end

  csi_cfg u_cfg (
    .clk(clk), .rst_n(srst_n), .wr_en(ctrl_wr), .wdata(reg_wdata[CTRL_W-1:0]),
    .pwr(pwr), .cfg(cfg)
  );

  csi_clkgen #(.SEL_W(CKS_W)) u_clk (
    .clk(clk), .rst_n(srst_n), .run(busy), .restart(start), .sel(cfg.cks),
    .sck_in(sck_in), .tick(tick)
  );

  csi_shift #(.DW(DW), .LW(LEN_W)) u_shift (
    .clk(clk), .rst_n(srst_n), .clr(~pwr), .start(start), .load(start_data),
    .lsb(cfg.lsb), .cpha(cfg.cpha), .txe(cfg.txe), .len(cfg.len), .tick(tick),
    .sin(sdi), .busy(busy), .done(done), .word(word), .sout(sdo), .tgl(tgl)
  );

  assert_single_drop_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_wr && busy && pwr && !cfg.cont && !done) |=> !irq_tx);
  assert_ovr_set_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (cap && full_q && !rx_rd) |=> ovr_q);
  assert_pwr_off_R3: assert property (@(posedge clk) disable iff (!srst_n)
    !pwr |=> (!busy && !ovr_q));
  assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (done && pend_q && pwr) |=> busy);
endmodule

// File: tb/sim_csi_ctrl.sv
module sim_csi_ctrl;
  import csi_pkg::*;

  logic        clk, rst_n, reg_wr, reg_rd, sck_in, sdi_hi, sdi;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, d;
  logic        sck_out, sdo, irq_rx, irq_tx;
  int          n_tests, n_fail;

  // {control word, tx data, expected rx, expected first data bit}
  localparam logic [48:0] VEC [6] = '{
    {16'h2007, 16'h00A5, 16'h00A5, 1'b1},
    {16'h204F, 16'h12C4, 16'h00C4, 1'b0},
    {16'h0027, 16'h8001, 16'h8001, 1'b1},
    {16'h040F, 16'hFFFE, 16'h0002, 1'b0},
    {16'h30E7, 16'h5ABC, 16'h0ABC, 1'b1},
    {16'h150F, 16'h0033, 16'h0013, 1'b1}
  };

  csi_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in), .sck_out(sck_out),
    .sdo(sdo), .sdi(sdi), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  assign sdi = sdo | sdi_hi;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic configure(input logic [15:0] w);
    wr(ADDR_CTRL, w & 16'hFFFE);
    wr(ADDR_CTRL, w);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      reg_addr = ADDR_STAT;
      #1;
      if (!reg_rdata[0]) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    sck_in = 1'b0; sdi_hi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(ADDR_CTRL, d); chk("R1 reset ctrl", d, 16'h0);
    peek(ADDR_STAT, d); chk("R1 reset stat", d, 16'h0);
    chk("R12 reset sck", {15'b0, sck_out}, 16'h0);
    chk("R1 reset irq", {14'b0, irq_rx, irq_tx}, 16'h0);

    // Vector table: loopback frames across lengths, orders, phases, dividers
    for (int i = 0; i < 6; i++) begin
      logic [48:0] v;
      v = VEC[i];
      configure(v[48:33]);
      peek(ADDR_CTRL, d); chk("R1 ctrl readback", d, v[48:33]);
      wr(ADDR_DATA, v[32:17]);
      chk("R4 first data bit R8", {15'b0, sdo}, {15'b0, v[0]});
      chk("R4 tx pulse", {15'b0, irq_tx}, 16'h1);
      wait_idle();
      chk("R12 idle sck level", {15'b0, sck_out}, {15'b0, v[38]});
      rd(ADDR_DATA, d); chk("R8 rx frame", d, v[16:1]);
      peek(ADDR_STAT, d); chk("R11 no overrun", d, 16'h0);
    end

    // R2 lock while powered; power-off keeps fields
    configure(16'h2007);
    wr(ADDR_CTRL, 16'h3FFF);
    peek(ADDR_CTRL, d); chk("R2 locked fields", d, 16'h2007);
    wr(ADDR_CTRL, 16'h0000);
    peek(ADDR_CTRL, d); chk("R2 power only", d, 16'h2006);

    // R10 phase 0: busy clears with rx pulse (8 bits, divide by 2)
    configure(16'h2007);
    wr(ADDR_DATA, 16'h003C);
    reg_addr = ADDR_STAT;
    repeat (15) @(negedge clk);
    #1 chk("R10 busy before end", {14'b0, irq_rx, reg_rdata[0]}, 16'h1);
    @(negedge clk);
    #1 chk("R10 phase0 clear", {14'b0, irq_rx, reg_rdata[0]}, 16'h2);

    // R10 phase 1: busy one half period later
    configure(16'h2047);
    wr(ADDR_DATA, 16'h003C);
    reg_addr = ADDR_STAT;
    repeat (16) @(negedge clk);
    #1 chk("R10 phase1 hold", {14'b0, irq_rx, reg_rdata[0]}, 16'h3);
    @(negedge clk);
    #1 chk("R10 phase1 clear", {15'b0, reg_rdata[0]}, 16'h0);

    // R9 divider k=2: frame of 8 bits ends 64 cycles after load
    configure(16'h2107);
    wr(ADDR_DATA, 16'h0081);
    reg_addr = ADDR_STAT;
    repeat (63) @(negedge clk);
    #1 chk("R9 div busy", {14'b0, irq_rx, reg_rdata[0]}, 16'h1);
    @(negedge clk);
    #1 chk("R9 div done", {14'b0, irq_rx, reg_rdata[0]}, 16'h2);

    // R9 external clock
    configure(16'h2387);
    wr(ADDR_DATA, 16'h0096);
    for (int i = 0; i < 16; i++) begin
      repeat (3) @(negedge clk);
      sck_in = ~sck_in;
      if (i == 5) chk("R9 ext sck idle", {15'b0, sck_out}, 16'h0);
    end
    repeat (6) @(negedge clk);
    wait_idle();
    rd(ADDR_DATA, d); chk("R9 ext frame", d, 16'h0096);

    // R5 single mode drop
    configure(16'h2007);
    wr(ADDR_DATA, 16'h005A);
    repeat (3) @(negedge clk);
    wr(ADDR_DATA, 16'h00FF);
    chk("R5 no tx pulse", {15'b0, irq_tx}, 16'h0);
    wait_idle();
    repeat (4) @(negedge clk);
    #1 chk("R5 no second frame", {15'b0, reg_rdata[0]}, 16'h0);
    rd(ADDR_DATA, d); chk("R5 first data kept", d, 16'h005A);

    // R6 receive-only read trigger
    configure(16'h2005);
    sdi_hi = 1'b1;
    rd(ADDR_DATA, d);
    peek(ADDR_STAT, d); chk("R6 read starts rx", {15'b0, d[0]}, 16'h1);
    rd(ADDR_DATA, d);
    wait_idle();
    repeat (4) @(negedge clk);
    #1 chk("R6 busy read ignored", {15'b0, reg_rdata[0]}, 16'h0);
    rd(ADDR_DATA, d); chk("R6 rx data", d, 16'h00FF);
    sdi_hi = 1'b0;

    // R7 continuous mode back-to-back
    configure(16'h2017);
    wr(ADDR_DATA, 16'h0011);
    repeat (3) @(negedge clk);
    wr(ADDR_DATA, 16'h0022);
    chk("R7 queued no pulse", {15'b0, irq_tx}, 16'h0);
    reg_addr = ADDR_STAT;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      if (irq_rx) break;
    end
    chk("R7 b2b busy and load", {14'b0, irq_tx, reg_rdata[0]}, 16'h3);
    rd(ADDR_DATA, d); chk("R7 first frame", d, 16'h0011);
    wait_idle();
    rd(ADDR_DATA, d); chk("R7 second frame", d, 16'h0022);
    peek(ADDR_STAT, d); chk("R7 no overrun", d, 16'h0);

    // R11 overrun and write-1 clear
    configure(16'h2007);
    wr(ADDR_DATA, 16'h0001); wait_idle();
    wr(ADDR_DATA, 16'h0002); wait_idle();
    peek(ADDR_STAT, d); chk("R11 overrun set", d, 16'h2);
    wr(ADDR_STAT, 16'h0002);
    peek(ADDR_STAT, d); chk("R11 overrun cleared", d, 16'h0);

    // R11 read on the completion edge
    configure(16'h2007);
    wr(ADDR_DATA, 16'h0033); wait_idle();
    wr(ADDR_DATA, 16'h000C);
    repeat (14) @(negedge clk);
    rd(ADDR_DATA, d); chk("R11 same-edge old data", d, 16'h0033);
    wait_idle();
    peek(ADDR_STAT, d); chk("R11 same-edge no overrun", d, 16'h0);
    rd(ADDR_DATA, d); chk("R11 same-edge new data", d, 16'h000C);

    // R3 power-off resets the interface mid-transfer
    configure(16'h2027);
    wr(ADDR_DATA, 16'h0001); wait_idle();
    wr(ADDR_DATA, 16'h0002); wait_idle();
    wr(ADDR_DATA, 16'h00F0);
    repeat (3) @(negedge clk);
    wr(ADDR_CTRL, 16'h2026);
    repeat (2) @(negedge clk);
    peek(ADDR_STAT, d); chk("R3 status cleared", d, 16'h0);
    rd(ADDR_DATA, d); chk("R3 rx cleared", d, 16'h0);
    chk("R3 lines idle", {14'b0, sck_out, sdo}, 16'h2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule